// File: doc/BRIEF.md
# Boot Overlay Sequencer

At power-up the processor begins fetching at address 0000, where normally no boot code lives. This sequencer raises a phantom signal that tells the card's address decoder to show boot ROM at 0000 for the first few fetches. It then withdraws the signal so the normal memory map returns. The ROM is expected to supply a one-byte no-operation (00) followed by a three-byte jump (C3, low byte, high byte) to the real entry point. For that reason the overlay lasts for exactly four qualified memory reads of the card.

The qualified read strobe is high while the card is selected and the read strobes are active. It passes through a synchroniser, and the sequencer counts its rising edges, so each access counts once however long it lasts. The count arms the release on the fourth rising edge. The phantom signal falls only after that fourth access finishes, so the last byte of the jump is still fetched through the overlay. After release the overlay stays off until the next power-on clear. A board switch selects where the phantom output comes from. When the switch is off, the output copies an external phantom request instead of the internal state.

Top module: `boot_overlay_seq`

## Requirements
- R1: While power-on clear (`powerOnClearN` low) is asserted, and after it is released, the overlay is active and the access count is zero. With `enableSw` high, `phantomOut` is 1.
- R2: With `enableSw` low, `phantomOut` equals `extPhantom` in every cycle, whatever the internal state.
- R3: Each rising edge of `readStrobe` counts as exactly one access, however many cycles the strobe is held high. The strobe must be high or low for at least one full clock period.
- R4: After zero to three counted accesses, `phantomOut` stays 1 (with `enableSw` high).
- R5: The fourth access still sees the overlay while its strobe is high. `phantomOut` falls on the third rising clock edge after `readStrobe` goes low at the end of that access. Two stages synchronise the strobe and one stage registers the state.
- R6: Once released, further reads of any number or length leave `phantomOut` at 0 (with `enableSw` high) until the next power-on clear.
- R7: A power-on clear at any point restores the overlay and restarts the count, so four fresh accesses are again needed for release. This includes the cycle in which a release would take effect.
- R8: With `enableSw` high, `extPhantom` has no effect on `phantomOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| powerOnClearN | input | 1 | Power-on clear, active low, asynchronous assert |
| readStrobe | input | 1 | Qualified memory read of the card (card selected and read active) |
| enableSw | input | 1 | 1: phantom output comes from the internal sequencer; 0: from `extPhantom` |
| extPhantom | input | 1 | External phantom request |
| phantomOut | output | 1 | Phantom signal to the address decoder |

## Verification
The release of the overlay and a power-on clear can fall in the same cycle. To provoke this, the bench drops the strobe of the fourth access and asserts the clear just before the edge on which the release would land. The run passes only if `phantomOut` stays high and a full four further accesses are again needed. A sweep from zero to six accesses, with varied strobe lengths, checks the output after every access against the count the bench keeps itself.

// File: rtl/boot_overlay_pkg.sv
package boot_overlay_pkg;

  // Overlay phase: counting accesses, waiting for the last one to end, done.
  typedef enum logic [1:0] {
    ST_OVERLAY  = 2'd0,
    ST_FINAL    = 2'd1,
    ST_RELEASED = 2'd2
  } ovlState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic countEn;
  } ctlStrobe_t;

endpackage

// File: rtl/boot_overlay_dp.sv
module boot_overlay_dp
  import boot_overlay_pkg::*;
#(
  parameter int ACCESS_COUNT = 4,
  parameter int SYNC_STAGES  = 2,
  localparam int CNT_W       = $clog2(ACCESS_COUNT + 1)
) (
  input  logic             clk,
  input  logic             powerOnClearN,
  input  logic             readStrobe,
  input  ctlStrobe_t       ctl,
  output logic             strobeRise,
  output logic             strobeFall,
  output logic             finalRise,
  output logic [CNT_W-1:0] accessCount
);

  localparam logic [CNT_W-1:0] LIMIT     = CNT_W'(ACCESS_COUNT);
  localparam logic [CNT_W-1:0] LAST_SEEN = CNT_W'(ACCESS_COUNT - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   strobeNow;
  logic                   strobeLast;

  // Synchroniser chain, one flop per stage.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge powerOnClearN) begin
        if (!powerOnClearN) syncChain[0] <= 1'b0;
        else                syncChain[0] <= readStrobe;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge powerOnClearN) begin
        if (!powerOnClearN) syncChain[g] <= 1'b0;
        else                syncChain[g] <= syncChain[g-1];
      end
    end
  end

  assign strobeNow = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge powerOnClearN) begin
    if (!powerOnClearN) strobeLast <= 1'b0;
    else                strobeLast <= strobeNow;
  end

  assign strobeRise = strobeNow & ~strobeLast;
  assign strobeFall = ~strobeNow & strobeLast;

  // Access counter, saturating at the release count.
  always_ff @(posedge clk or negedge powerOnClearN) begin
    if (!powerOnClearN) begin
      accessCount <= '0;
    end else if (ctl.countEn && strobeRise && (accessCount != LIMIT)) begin
      accessCount <= accessCount + 1'b1;
    end
  end

  assign finalRise = ctl.countEn & strobeRise & (accessCount == LAST_SEEN);

endmodule

// File: rtl/boot_overlay_ctl.sv
module boot_overlay_ctl
  import boot_overlay_pkg::*;
(
  input  logic       clk,
  input  logic       powerOnClearN,
  input  logic       finalRise,
  input  logic       strobeFall,
  input  logic       enableSw,
  input  logic       extPhantom,
  output ctlStrobe_t ctl,
  output logic       overlayActive,
  output logic       phantomOut
);

  ovlState_t state;
  ovlState_t stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_OVERLAY:  if (finalRise)  stateNext = ST_FINAL;
      ST_FINAL:    if (strobeFall) stateNext = ST_RELEASED;
      ST_RELEASED: stateNext = ST_RELEASED;
      default:     stateNext = ST_OVERLAY;
    endcase
  end

  always_ff @(posedge clk or negedge powerOnClearN) begin
    if (!powerOnClearN) state <= ST_OVERLAY;
    else                state <= stateNext;
  end

  always_comb begin
    ctl         = '0;
    ctl.countEn = (state == ST_OVERLAY);
  end

  assign overlayActive = (state != ST_RELEASED);
  assign phantomOut    = enableSw ? overlayActive : extPhantom;

endmodule

// File: rtl/boot_overlay_seq.sv
module boot_overlay_seq
  import boot_overlay_pkg::*;
#(
  parameter int ACCESS_COUNT = 4,
  parameter int SYNC_STAGES  = 2,
  localparam int CNT_W       = $clog2(ACCESS_COUNT + 1)
) (
  input  logic clk,
  input  logic powerOnClearN,
  input  logic readStrobe,
  input  logic enableSw,
  input  logic extPhantom,
  output logic phantomOut
);

  ctlStrobe_t       ctl;
  logic             strobeRise;
  logic             strobeFall;
  logic             finalRise;
  logic             overlayActive;
  logic [CNT_W-1:0] accessCount;

  boot_overlay_dp #(
    .ACCESS_COUNT(ACCESS_COUNT),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk          (clk),
    .powerOnClearN(powerOnClearN),
    .readStrobe   (readStrobe),
    .ctl          (ctl),
    .strobeRise   (strobeRise),
    .strobeFall   (strobeFall),
    .finalRise    (finalRise),
    .accessCount  (accessCount)
  );

  boot_overlay_ctl ctl_i (
    .clk          (clk),
    .powerOnClearN(powerOnClearN),
    .finalRise    (finalRise),
    .strobeFall   (strobeFall),
    .enableSw     (enableSw),
    .extPhantom   (extPhantom),
    .ctl          (ctl),
    .overlayActive(overlayActive),
    .phantomOut   (phantomOut)
  );

endmodule

// File: rtl/boot_overlay_seq_chk.sv
module boot_overlay_seq_chk #(
  parameter int ACCESS_COUNT = 4,
  localparam int CNT_W       = $clog2(ACCESS_COUNT + 1)
) (
  input logic             clk,
  input logic             powerOnClearN,
  input logic             overlayActive,
  input logic             strobeFall,
  input logic [CNT_W-1:0] accessCount
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ACCESS_COUNT);

  // R6: no return to the overlay without a power-on clear
  a_r6_no_reentry: assert property (@(posedge clk) disable iff (!powerOnClearN)
    !overlayActive |=> !overlayActive);

  // R5: release comes only after the end of an access
  a_r5_release_on_fall: assert property (@(posedge clk) disable iff (!powerOnClearN)
    $fell(overlayActive) |-> $past(strobeFall));

  // R5: release needs the full number of accesses
  a_r5_release_count: assert property (@(posedge clk) disable iff (!powerOnClearN)
    $fell(overlayActive) |-> (accessCount == LIMIT));

  // R3: the count moves by at most one per cycle
  a_r3_single_step: assert property (@(posedge clk) disable iff (!powerOnClearN)
    (accessCount != $past(accessCount)) |-> (accessCount == $past(accessCount) + 1'b1));

  // R3: the count never passes the limit
  a_r3_bounded: assert property (@(posedge clk) disable iff (!powerOnClearN)
    accessCount <= LIMIT);

  // R4: overlay held while the count is short
  a_r4_hold_short: assert property (@(posedge clk) disable iff (!powerOnClearN)
    (accessCount < LIMIT) |-> overlayActive);

endmodule

bind boot_overlay_seq boot_overlay_seq_chk #(.ACCESS_COUNT(ACCESS_COUNT)) chk_i (
  .clk          (clk),
  .powerOnClearN(powerOnClearN),
  .overlayActive(overlayActive),
  .strobeFall   (strobeFall),
  .accessCount  (accessCount)
);

// File: tb/boot_overlay_seq_tb.sv
module boot_overlay_seq_tb_top;

  logic clk = 1'b0;
  logic powerOnClearN = 1'b0;
  logic readStrobe = 1'b0;
  logic enableSw = 1'b1;
  logic extPhantom = 1'b0;
  logic phantomOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  boot_overlay_seq dut_i (
    .clk          (clk),
    .powerOnClearN(powerOnClearN),
    .readStrobe   (readStrobe),
    .enableSw     (enableSw),
    .extPhantom   (extPhantom),
    .phantomOut   (phantomOut)
  );

  task automatic check(input string req, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: phantomOut=%0b expected=%0b at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic porPulse();
    @(negedge clk);
    powerOnClearN = 1'b0;
    @(negedge clk);
    powerOnClearN = 1'b1;
    @(negedge clk);
  endtask

  // One access: strobe high for 'hold' cycles, then low long enough to settle.
  task automatic doRead(input int hold);
    @(negedge clk);
    readStrobe = 1'b1;
    repeat (hold) @(negedge clk);
    readStrobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1;
    check("R1 during clear", phantomOut, 1'b1);
    repeat (3) @(negedge clk);
    powerOnClearN = 1'b1;
    @(negedge clk);
    check("R1 after clear", phantomOut, 1'b1);

    // Sweep 0..6 accesses with varied strobe lengths.
    for (int n = 0; n <= 6; n++) begin
      porPulse();
      check("R1 fresh clear", phantomOut, 1'b1);
      for (int i = 0; i < n; i++) begin
        doRead((i == 0) ? 30 : 1 + (i % 3));
        if (i + 1 < 4)      check("R3/R4 overlay held", phantomOut, 1'b1);
        else if (i + 1 == 4) check("R5 released after fourth", phantomOut, 1'b0);
        else                check("R6 stays released", phantomOut, 1'b0);
      end
    end

    // R5 exact release timing.
    porPulse();
    repeat (3) doRead(2);
    @(negedge clk);
    readStrobe = 1'b1;
    repeat (6) @(negedge clk);
    check("R5 fourth access sees overlay", phantomOut, 1'b1);
    readStrobe = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 still high two edges after drop", phantomOut, 1'b1);
    @(negedge clk);
    check("R5 low three edges after drop", phantomOut, 1'b0);

    // R6 long read after release.
    doRead(40);
    check("R6 long read after release", phantomOut, 1'b0);

    // R7 clear coinciding with the release cycle.
    porPulse();
    repeat (3) doRead(1);
    @(negedge clk);
    readStrobe = 1'b1;
    repeat (3) @(negedge clk);
    readStrobe = 1'b0;
    repeat (2) @(negedge clk);
    powerOnClearN = 1'b0;
    @(negedge clk);
    check("R7 clear wins over release", phantomOut, 1'b1);
    powerOnClearN = 1'b1;
    repeat (3) doRead(2);
    check("R7 three fresh reads not enough", phantomOut, 1'b1);
    doRead(2);
    check("R7 fourth fresh read releases", phantomOut, 1'b0);

    // R2 switch off: follow external request in released state.
    for (int e = 0; e < 2; e++) begin
      enableSw = 1'b0;
      extPhantom = logic'(e);
      #1;
      check("R2 released, switch off", phantomOut, logic'(e));
    end
    // R8 switch on: external ignored in released state.
    enableSw = 1'b1;
    for (int e = 0; e < 2; e++) begin
      extPhantom = logic'(e);
      #1;
      check("R8 ext ignored, released", phantomOut, 1'b0);
    end
    // Same pair in overlay state.
    porPulse();
    for (int e = 0; e < 2; e++) begin
      enableSw = 1'b0;
      extPhantom = logic'(e);
      #1;
      check("R2 overlay, switch off", phantomOut, logic'(e));
      enableSw = 1'b1;
      #1;
      check("R8 ext ignored, overlay", phantomOut, 1'b1);
    end
    // R2: counting continues while switch off; output still follows ext.
    enableSw = 1'b0;
    extPhantom = 1'b1;
    repeat (4) doRead(1);
    check("R2 follows ext after release", phantomOut, 1'b1);
    enableSw = 1'b1;
    #1;
    check("R6 internal state released", phantomOut, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule